// File: doc/BRIEF.md
# Variable-Precision Road Pattern Matcher

This block is a small content-addressable bank of track patterns. Every pattern keeps one stored coarse word for each detector layer, with a don't-care count per layer that removes a chosen number of low-order bits from the comparison. During an event, hit words arrive on parallel per-layer buses. Each layer cell of each pattern latches a sticky match flag when any accepted hit on its bus agrees with the stored word on the compared bits. The cell also records which of four finer subdivisions of the coarse word were seen, using the two bits just below the compared field.

An event opens with a one-cycle `ev_init` pulse, which clears all flags, and closes with `ev_end`. The block then enters readout. A pattern whose count of matched layers reaches the firing threshold is a fired road. Fired roads are streamed out on a valid/ready interface, lowest pattern address first. Each road carries its identifier, a per-layer match bitmap and four subdivision bits per layer. An accepted road is killed from the pending set. When no road is left, `ev_done` pulses for one cycle and the block returns to idle.

Patterns are loaded through a plain write port while the block is idle. Back-pressure rules on the road stream: while `road_valid` is high and `road_ready` is low, the road and all of its fields stay unchanged. A road is consumed only in a cycle where both are high. Hits are taken only in cycles where `hit_ready` is high. There is no buffering, so a hit presented while `hit_ready` is low is dropped.

Top module: `vp_road_matcher`

## Requirements
- R1: After reset `road_valid`, `hit_ready` and `ev_done` are low and the block is idle. Every stored word and don't-care count is zero, and every match flag is clear.
- R2: A layer flag of a pattern sets when an accepted hit on that layer's bus equals the stored word on every compared bit. Hits for different layers may arrive in different cycles of the same event.
- R3: Match flags stay set for the whole event. An accepted `ev_init` clears them all. Hits accepted in the same cycle as `ev_init` count for the new event.
- R4: With a don't-care count n on a layer, bits [n-1:0] are left out of that layer's comparison. A written count above the word width is clamped to the word width, so the layer matches any hit.
- R5: A pattern fires when its number of matched layers is at least `fire_min`. A `fire_min` of 0, or one above the layer count, means all layers.
- R6: Fired roads are output in ascending pattern address, one per accepted handshake, with no repeats. `road_id` is the pattern address zero-extended to 18 bits.
- R7: While `road_valid` is high and `road_ready` is low, `road_valid`, `road_id`, `road_map` and `road_sub` hold.
- R8: Bit l of `road_map` is set exactly when layer l of the road's pattern matched in the event.
- R9: Bits [4l+3:4l] of `road_sub` hold one bit per subdivision of layer l. Bit k is set if a matching hit on layer l had bits [n-1:n-2] equal to k. When n is below 2, every match sets bit 0.
- R10: `ev_done` is high for exactly one cycle: the first readout cycle with no pending road. That is the cycle after the last road is accepted, or the cycle after `ev_end` when no road fired. The block is idle in the next cycle.
- R11: Configuration writes take effect only while idle. `hit_ready` is high only while collecting or during an accepted `ev_init`. `ev_init` is ignored during readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write one layer cell of one pattern |
| cfg_pat | input | 6 | Pattern address to write |
| cfg_layer | input | 3 | Layer index to write |
| cfg_word | input | 18 | Stored coarse word |
| cfg_dc | input | 5 | Count of low bits left out of the comparison |
| fire_min | input | 3 | Minimum matched layers for a road to fire (0 = all) |
| ev_init | input | 1 | Start a new event and clear the flags |
| ev_end | input | 1 | Close collection and start readout |
| hit_valid | input | 6 | Per-layer hit valid |
| hit_word | input | 108 | Per-layer hit words, layer l at bits [18l+17:18l] |
| hit_ready | output | 1 | Hits are accepted in this cycle |
| road_valid | output | 1 | A fired road is presented |
| road_ready | input | 1 | Consumer accepts the road |
| road_id | output | 18 | Pattern address of the road |
| road_map | output | 6 | Per-layer match bitmap |
| road_sub | output | 24 | Four subdivision bits per layer |
| ev_done | output | 1 | One-cycle end-of-event pulse |

## Verification
A hit accepted at a rising edge sets its flags at that edge. The first road appears in the cycle after the `ev_end` edge, because fired state is read straight from the flags. Each later road appears one cycle after the handshake that killed the previous road. `ev_done` shows in the cycle after the last handshake, or in the cycle after `ev_end` when no road fired. The bench changes inputs on the falling edge and samples on the next falling edge, so each result is read half a cycle after the rising edge that produced it. Back-pressure is checked by keeping `road_ready` low for several such samples and re-reading the same road.

// File: rtl/vpam_pkg.sv
package vpam_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_READOUT = 2'd2
  } phase_t;
endpackage

// File: rtl/vpam_layer_cell.sv
module vpam_layer_cell #(
  parameter int WORD_W = 18,
  parameter int DC_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [DC_W-1:0]   cfg_dc,
  input  logic              ev_clear,
  input  logic              hit_acc,
  input  logic [WORD_W-1:0] hit_word,
  output logic              matched,
  output logic [3:0]        sub_hit
);
  localparam logic [DC_W-1:0] DC_MAX = DC_W'(WORD_W);
  localparam logic [DC_W-1:0] DC_TWO = DC_W'(2);

  logic [WORD_W-1:0] stored_q;
  logic [DC_W-1:0]   dc_q;
  logic [WORD_W-1:0] care;
  logic [DC_W-1:0]   shamt;
  logic [1:0]        sub_idx;
  logic [3:0]        sub_onehot;
  logic              hit_now;

  always_comb begin
    for (int b = 0; b < WORD_W; b++) begin
      care[b] = (DC_W'(b) >= dc_q);
    end
    shamt      = (dc_q >= DC_TWO) ? dc_q - DC_TWO : '0;
    sub_idx    = (dc_q >= DC_TWO) ? 2'(hit_word >> shamt) : 2'd0;
    sub_onehot = 4'b0001 << sub_idx;
    hit_now    = hit_acc && (((hit_word ^ stored_q) & care) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
      dc_q     <= '0;
    end else if (cfg_we) begin
      stored_q <= cfg_word;
      dc_q     <= (cfg_dc > DC_MAX) ? DC_MAX : cfg_dc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      matched <= 1'b0;
      sub_hit <= '0;
    end else if (ev_clear) begin
      matched <= hit_now;
      sub_hit <= hit_now ? sub_onehot : 4'b0000;
    end else if (hit_now) begin
      matched <= 1'b1;
      sub_hit <= sub_hit | sub_onehot;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    matched && !ev_clear |=> matched); // R3
  AST_DC_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> dc_q <= DC_MAX); // R4
endmodule

// File: rtl/vpam_pattern.sv
module vpam_pattern #(
  parameter int NUM_LAYERS = 6,
  parameter int WORD_W     = 18,
  parameter int DC_W       = 5,
  parameter int LAY_AW     = 3,
  parameter int CNT_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [LAY_AW-1:0]            cfg_layer,
  input  logic [WORD_W-1:0]            cfg_word,
  input  logic [DC_W-1:0]              cfg_dc,
  input  logic                         ev_clear,
  input  logic [NUM_LAYERS-1:0]        hit_acc,
  input  logic [NUM_LAYERS*WORD_W-1:0] hit_word,
  input  logic [CNT_W-1:0]             thr,
  output logic [NUM_LAYERS-1:0]        layer_map,
  output logic [4*NUM_LAYERS-1:0]      sub_map,
  output logic                         fired
);
  logic [CNT_W-1:0] match_cnt;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    vpam_layer_cell #(.WORD_W(WORD_W), .DC_W(DC_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we && (cfg_layer == LAY_AW'(l))),
      .cfg_word (cfg_word),
      .cfg_dc   (cfg_dc),
      .ev_clear (ev_clear),
      .hit_acc  (hit_acc[l]),
      .hit_word (hit_word[l*WORD_W +: WORD_W]),
      .matched  (layer_map[l]),
      .sub_hit  (sub_map[4*l +: 4])
    );
  end

  always_comb begin
    match_cnt = '0;
    for (int l = 0; l < NUM_LAYERS; l++) begin
      match_cnt = match_cnt + CNT_W'(layer_map[l]);
    end
    fired = (match_cnt >= thr);
  end
endmodule

// File: rtl/vpam_road_encoder.sv
module vpam_road_encoder #(
  parameter int NUM_PAT = 64,
  parameter int PAT_AW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [NUM_PAT-1:0] fired,
  input  logic              take,
  output logic              any,
  output logic [PAT_AW-1:0] sel_id
);
  logic [NUM_PAT-1:0] killed_q;
  logic [NUM_PAT-1:0] pending;

  assign pending = fired & ~killed_q;

  always_comb begin
    any    = 1'b0;
    sel_id = '0;
    for (int i = NUM_PAT - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any    = 1'b1;
        sel_id = PAT_AW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      killed_q <= '0;
    end else if (clear) begin
      killed_q <= '0;
    end else if (take && any) begin
      killed_q[sel_id] <= 1'b1;
    end
  end

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    take && !clear |=> !(any && sel_id == $past(sel_id))); // R6
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take && !clear |=> !any || (sel_id > $past(sel_id))); // R6
endmodule

// File: rtl/vp_road_matcher.sv
module vp_road_matcher #(
  parameter int NUM_PAT    = 64,
  parameter int NUM_LAYERS = 6,
  parameter int WORD_W     = 18,
  parameter int ID_W       = 18,
  localparam int PAT_AW    = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1,
  localparam int LAY_AW    = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
  localparam int DC_W      = $clog2(WORD_W + 1),
  localparam int CNT_W     = $clog2(NUM_LAYERS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [PAT_AW-1:0]            cfg_pat,
  input  logic [LAY_AW-1:0]            cfg_layer,
  input  logic [WORD_W-1:0]            cfg_word,
  input  logic [DC_W-1:0]              cfg_dc,
  input  logic [CNT_W-1:0]             fire_min,
  input  logic                         ev_init,
  input  logic                         ev_end,
  input  logic [NUM_LAYERS-1:0]        hit_valid,
  input  logic [NUM_LAYERS*WORD_W-1:0] hit_word,
  output logic                         hit_ready,
  output logic                         road_valid,
  input  logic                         road_ready,
  output logic [ID_W-1:0]              road_id,
  output logic [NUM_LAYERS-1:0]        road_map,
  output logic [4*NUM_LAYERS-1:0]      road_sub,
  output logic                         ev_done
);
  import vpam_pkg::*;

  phase_t phase_q;
  logic   ev_clear;
  logic   cfg_ok;
  logic   take;
  logic   any_road;
  logic [PAT_AW-1:0]            sel_id;
  logic [CNT_W-1:0]             thr_eff;
  logic [NUM_LAYERS-1:0]        hit_acc;
  logic [NUM_PAT-1:0]           fired;
  logic [NUM_LAYERS-1:0]        map_all [NUM_PAT];
  logic [4*NUM_LAYERS-1:0]      sub_all [NUM_PAT];

  assign ev_clear  = ev_init && (phase_q != PH_READOUT);
  assign cfg_ok    = cfg_we && (phase_q == PH_IDLE);
  assign hit_ready = (phase_q == PH_COLLECT) || ev_clear;
  assign hit_acc   = hit_valid & {NUM_LAYERS{hit_ready}};
  assign thr_eff   = ((fire_min == '0) || (fire_min > CNT_W'(NUM_LAYERS)))
                     ? CNT_W'(NUM_LAYERS) : fire_min;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    vpam_pattern #(
      .NUM_LAYERS (NUM_LAYERS),
      .WORD_W     (WORD_W),
      .DC_W       (DC_W),
      .LAY_AW     (LAY_AW),
      .CNT_W      (CNT_W)
    ) u_pat (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_ok && (cfg_pat == PAT_AW'(p))),
      .cfg_layer (cfg_layer),
      .cfg_word  (cfg_word),
      .cfg_dc    (cfg_dc),
      .ev_clear  (ev_clear),
      .hit_acc   (hit_acc),
      .hit_word  (hit_word),
      .thr       (thr_eff),
      .layer_map (map_all[p]),
      .sub_map   (sub_all[p]),
      .fired     (fired[p])
    );
  end

  vpam_road_encoder #(.NUM_PAT(NUM_PAT), .PAT_AW(PAT_AW)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ev_clear),
    .fired  (fired),
    .take   (take),
    .any    (any_road),
    .sel_id (sel_id)
  );

  assign road_valid = (phase_q == PH_READOUT) && any_road;
  assign take       = road_valid && road_ready;
  assign ev_done    = (phase_q == PH_READOUT) && !any_road;
  assign road_id    = ID_W'(sel_id);
  assign road_map   = map_all[sel_id];
  assign road_sub   = sub_all[sel_id];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE:    if (ev_init) phase_q <= PH_COLLECT;
        PH_COLLECT: if (!ev_init && ev_end) phase_q <= PH_READOUT;
        PH_READOUT: if (!any_road) phase_q <= PH_IDLE;
        default:    phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_ROAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid && !road_ready |=> road_valid && $stable(road_id)
      && $stable(road_map) && $stable(road_sub)); // R7
  AST_NO_HITS_IN_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READOUT) |-> !hit_ready); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !ev_done && (phase_q == PH_IDLE)); // R10
  AST_FIRED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    road_valid |-> ($countones(road_map) >= int'(thr_eff))); // R5
endmodule

// File: tb/vp_road_matcher_test.sv
module vp_road_matcher_test;
  localparam int NP = 64;
  localparam int L  = 6;
  localparam int W  = 18;

  typedef struct packed {
    logic [4:0]  dc;
    logic [17:0] stored;
    logic [17:0] hit;
    logic        hit_ok;
    logic [3:0]  sub;
  } row_t;

  localparam row_t ROWS [8] = '{
    '{5'd0,  18'h12345, 18'h12345, 1'b1, 4'b0001},
    '{5'd0,  18'h12345, 18'h12344, 1'b0, 4'b0000},
    '{5'd4,  18'h12340, 18'h1234B, 1'b1, 4'b0100},
    '{5'd4,  18'h12340, 18'h1235F, 1'b0, 4'b0000},
    '{5'd2,  18'h00100, 18'h00103, 1'b1, 4'b1000},
    '{5'd8,  18'h3FF00, 18'h3FF7A, 1'b1, 4'b0010},
    '{5'd31, 18'h00000, 18'h00001, 1'b1, 4'b0001},
    '{5'd1,  18'h2AAAA, 18'h2AAAB, 1'b1, 4'b0001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_pat = '0;
  logic [2:0] cfg_layer = '0;
  logic [17:0] cfg_word = '0;
  logic [4:0] cfg_dc = '0;
  logic [2:0] fire_min = '0;
  logic ev_init = 1'b0;
  logic ev_end = 1'b0;
  logic [5:0] hit_valid = '0;
  logic [107:0] hit_word = '0;
  logic hit_ready;
  logic road_valid;
  logic road_ready = 1'b0;
  logic [17:0] road_id;
  logic [5:0] road_map;
  logic [23:0] road_sub;
  logic ev_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vp_road_matcher uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pat(cfg_pat),
    .cfg_layer(cfg_layer), .cfg_word(cfg_word), .cfg_dc(cfg_dc),
    .fire_min(fire_min), .ev_init(ev_init), .ev_end(ev_end),
    .hit_valid(hit_valid), .hit_word(hit_word), .hit_ready(hit_ready),
    .road_valid(road_valid), .road_ready(road_ready), .road_id(road_id),
    .road_map(road_map), .road_sub(road_sub), .ev_done(ev_done)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [107:0] pw(input int p);
    logic [107:0] v;
    for (int l = 0; l < L; l++) v[l*W +: W] = 18'(32'h1000 + p * 16 + l);
    return v;
  endfunction

  task automatic cfg(input int p, input int l, input logic [17:0] w, input logic [4:0] dc);
    cfg_we = 1'b1; cfg_pat = 6'(p); cfg_layer = 3'(l); cfg_word = w; cfg_dc = dc;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_pattern(input int p);
    logic [107:0] v;
    v = pw(p);
    for (int l = 0; l < L; l++) cfg(p, l, v[l*W +: W], 5'd0);
  endtask

  task automatic hits(input logic [5:0] m, input logic [107:0] w, input logic init);
    hit_valid = m; hit_word = w; ev_init = init;
    step();
    hit_valid = '0; ev_init = 1'b0;
  endtask

  task automatic end_ev();
    ev_end = 1'b1;
    step();
    ev_end = 1'b0;
  endtask

  task automatic pop(input string req, input int id, input logic [5:0] m, input logic [23:0] s);
    chk({req, " valid"}, 64'(road_valid), 64'd1);
    chk({req, " id"}, 64'(road_id), 64'(id));
    chk({req, " map"}, 64'(road_map), 64'(m));
    chk({req, " sub"}, 64'(road_sub), 64'(s));
    road_ready = 1'b1;
    step();
    road_ready = 1'b0;
  endtask

  task automatic done(input string req);
    chk({req, " done"}, 64'(ev_done), 64'd1);
    chk({req, " no road"}, 64'(road_valid), 64'd0);
    step();
    chk({req, " done drops"}, 64'(ev_done), 64'd0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected finish");
    finish_run();
  end

  initial begin
    step();
    step();
    // R1: reset state
    chk("R1 road_valid", 64'(road_valid), 64'd0);
    chk("R1 hit_ready", 64'(hit_ready), 64'd0);
    chk("R1 ev_done", 64'(ev_done), 64'd0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after release", 64'({road_valid, hit_ready, ev_done}), 64'd0);

    // R2 R4 R8 R9: table of single-pattern precision cases on pattern 5
    for (int r = 0; r < 8; r++) begin
      for (int l = 0; l < L; l++) cfg(5, l, ROWS[r].stored, ROWS[r].dc);
      hits(6'h3F, {6{ROWS[r].hit}}, 1'b1);
      end_ev();
      if (ROWS[r].hit_ok) pop($sformatf("R4 row %0d", r), 5, 6'h3F, {6{ROWS[r].sub}});
      done($sformatf("R2 row %0d", r));
    end

    // R6 R7: three roads in ascending order, back-pressure held
    cfg_pattern(3); cfg_pattern(9); cfg_pattern(40);
    hits('0, '0, 1'b1);
    chk("R11 hit_ready collecting", 64'(hit_ready), 64'd1);
    hits(6'h3F, pw(40), 1'b0);
    hits(6'h3F, pw(9), 1'b0);
    hits(6'h3F, pw(3), 1'b0);
    end_ev();
    chk("R11 hit_ready in readout", 64'(hit_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      chk("R7 valid held", 64'(road_valid), 64'd1);
      chk("R7 id held", 64'(road_id), 64'd3);
      step();
    end
    pop("R6 first", 3, 6'h3F, 24'h111111);
    pop("R6 second", 9, 6'h3F, 24'h111111);
    pop("R6 third", 40, 6'h3F, 24'h111111);
    done("R10 after roads");

    // R5: partial match across two cycles against thresholds
    fire_min = 3'd4;
    hits('0, '0, 1'b1);
    hits(6'h03, pw(9), 1'b0);
    hits(6'h0C, pw(9), 1'b0);
    end_ev();
    pop("R5 min4", 9, 6'h0F, 24'h001111);
    done("R5 min4");
    fire_min = 3'd5;
    hits(6'h0F, pw(9), 1'b1);
    end_ev();
    done("R5 min5 no road");
    fire_min = 3'd7;
    hits(6'h0F, pw(9), 1'b1);
    end_ev();
    done("R5 above count means all");
    fire_min = 3'd0;

    // R3: ev_init clears earlier matches; same-cycle hits kept
    hits(6'h3F, pw(3), 1'b1);
    hits(6'h3F, pw(9), 1'b1);
    end_ev();
    pop("R3 new event only", 9, 6'h3F, 24'h111111);
    done("R3");

    // R11: config write outside idle ignored, idle hits dropped
    hits('0, '0, 1'b1);
    cfg(3, 0, 18'h3FFFF, 5'd0);
    end_ev();
    done("R11 empty event");
    hit_valid = 6'h3F; hit_word = pw(3);
    chk("R11 hit_ready idle", 64'(hit_ready), 64'd0);
    step();
    hit_valid = '0;
    hits('0, '0, 1'b1);
    end_ev();
    done("R11 idle hits dropped");
    hits(6'h3F, pw(3), 1'b1);
    end_ev();
    ev_init = 1'b1;
    step();
    ev_init = 1'b0;
    pop("R11 write ignored, init in readout ignored", 3, 6'h3F, 24'h111111);
    done("R11");

    // R9: two subdivisions on one layer accumulate
    cfg(3, 0, 18'h01030, 5'd2);
    hits(6'h3F, pw(3), 1'b1);
    hits(6'h01, 108'(18'h01033), 1'b0);
    end_ev();
    pop("R9 two subdivisions", 3, 6'h3F, 24'h111119);
    done("R9");

    finish_run();
  end
endmodule